// File: doc/BRIEF.md
# SMBus Register-Model Transaction Sequencer

This block gives software a small byte-addressed register bank that describes one SMBus transaction: target address, command code, a 32-byte data buffer, a byte count and two spare alarm data bytes. Software fills in these registers while the block is idle. It then writes a single protocol byte, which selects the transaction type, the direction and whether a packet error code is used. That write starts the transaction.

The sequencer then drives an abstract byte-level bus model one step at a time: start (or repeated start), send a byte, receive a byte, stop. Each step is held until the bus model answers. For a sent byte the answer carries an ack or a nack. For a received byte it carries the data. When the stop step ends, the block sets a DONE flag and a 5-bit completion code in the status register. The electrical SCL/SDA timing lives in the bus model and is outside this block.

Top module: `smbus_seq`

## Requirements
- R1: Register offsets are: 0x00 protocol, 0x01 status, 0x02 address, 0x03 command, 0x04..0x23 data bytes 0..31, 0x24 byte count, 0x25 alarm address, 0x26..0x27 alarm data. After reset every register reads 0. While idle, writes to 0x02..0x27 read back unchanged. Writes to status are ignored. Offsets 0x28..0x3F read 0.
- R2: Status reads {DONE, 2'b00, code[4:0]}. A protocol write in idle clears DONE and the code. DONE stays 0 while a transaction runs and becomes 1 after its stop step.
- R3: The supported protocol values (bit 7 aside) are 0x02/0x03 quick, 0x04/0x05 byte, 0x06/0x07 byte-data, 0x08/0x09 word, 0x0A/0x0B block, 0x0C process call, 0x0D block process call and 0x4A/0x4B raw block. Any other value sets DONE with code 0x19 one cycle later, and no bus step is issued.
- R4: bus_op encodes 0 start, 1 send, 2 receive and 3 stop. bus_req holds with a stable op and byte until bus_rsp. Every address byte sent is {address[7:1], rw}, where rw is 1 for a read; address register bit 0 is ignored.
- R5: Writes (protocol bit 0 = 0) send the following after the address:
  - quick: nothing;
  - byte: the command byte;
  - byte-data: the command, then data 0;
  - word: the command, then data 0 (low byte) and data 1 (high byte);
  - block: the command, the count, then that many data bytes;
  - raw block: the command, then count data bytes, with no count byte.
- R6: Reads work as follows:
  - quick and byte reads use a read address directly; a byte read returns one byte into data 0.
  - Byte-data, word, block and raw-block reads send the write address and the command, then a repeated start and a read address.
  - Received bytes fill data from offset 0. A block read first receives a count, which is stored at 0x24.
  - A raw-block read takes its length from 0x24.
- R7: A process call sends the command and data 0..1, then receives a word into data 0..1. A block process call sends the command, the count and the data, then receives a count and that many bytes.
- R8: A write count above 32 is clamped to 32 for both the count byte sent and the number of data bytes. The count register is not changed by a write.
- R9: A nack on any address byte ends the transaction with a stop and code 0x10. A nack on any other sent byte ends it with a stop and code 0x11.
- R10: A received count above 32 ends the transaction with a stop and code 0x11. No data byte is received and the count register is unchanged.
- R11: With protocol bit 7 set (not quick), a CRC-8 (x^8+x^2+x+1, initial value 0) runs over every sent and received byte, including address bytes. Writes send it before the stop; reads receive it as the last byte. A mismatch gives code 0x1F.
- R12: While a transaction runs, register writes, including protocol writes, are ignored.
- R13: bus_last is 1 during the final receive step of a transaction (the PEC byte when PEC is on, otherwise the last data byte) and 0 on every other receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_req | output | 1 | Bus step requested |
| bus_op | output | 2 | Step kind: 0 start, 1 send, 2 receive, 3 stop |
| bus_tx | output | 8 | Byte to send |
| bus_last | output | 1 | Final receive of the transaction |
| bus_rsp | input | 1 | Step completed (one cycle) |
| bus_nack | input | 1 | Sent byte was not acknowledged |
| bus_rx | input | 8 | Received byte |

## Verification
The hardest situations to reach are the abnormal endings deep inside a transaction:
- a nack on the repeated-start address,
- a received block count of 33,
- a corrupted PEC byte on a read.

Each needs the bus responder to misbehave at one exact step. The bench's responder therefore counts sent bytes and nacks a chosen one. It also returns bytes from a scripted queue, which the bench builds and can corrupt before the protocol write. All protocol codes are swept with and without PEC against a step list derived from the requirements. Every one of the 256 protocol values is also tried for rejection.

// File: rtl/smbus_seq.sv
`timescale 1ns/1ps
module smbus_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_req,
  output logic [1:0] bus_op,
  output logic [7:0] bus_tx,
  output logic       bus_last,
  input  logic       bus_rsp,
  input  logic       bus_nack,
  input  logic [7:0] bus_rx
);
  localparam int BUF_N = 32;
  localparam logic [5:0] DATA_LO = 6'h04;
  localparam logic [5:0] DATA_HI = 6'h23;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDRW, S_CMD, S_WCNT, S_WDATA, S_RSTART,
    S_ADDRR, S_RCNT, S_RDATA, S_WPEC, S_RPEC, S_STOP
  } st_t;

  st_t        st, st_d;
  logic [7:0] prot_q, addr_q, cmd_q, bcnt_q, alrm_a_q, alrm_d0_q, alrm_d1_q, crc_q;
  logic [7:0] data_q [BUF_N];
  logic [4:0] code_q, errc;
  logic       done_q, err;
  logic [5:0] idx_q, idx_d, len_q, len_d, rn, wlen, rlen, bcnt_cl;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic logic supported(input logic [7:0] p);
    return (p[6:1] inside {6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h25}) || p[6:0] == 7'h0C || p[6:0] == 7'h0D;
  endfunction

  wire rd       = prot_q[0];
  wire is_quick = prot_q[6:1] == 6'h01;
  wire is_byte  = prot_q[6:1] == 6'h02;
  wire is_bd    = prot_q[6:1] == 6'h03;
  wire is_word  = prot_q[6:1] == 6'h04;
  wire is_blk   = prot_q[6:1] == 6'h05;
  wire is_i2c   = prot_q[6:1] == 6'h25;
  wire is_pc    = prot_q[6:0] == 7'h0C;
  wire is_bpc   = prot_q[6:0] == 7'h0D;
  wire pec_en   = prot_q[7] && !is_quick;
  wire first_rd = (is_quick || is_byte) && rd;
  wire rd_phase = (rd && (is_bd || is_word || is_blk || is_i2c)) || is_pc || is_bpc;
  wire cnt_out  = (is_blk && !rd) || is_bpc;
  wire cnt_in   = (is_blk && rd) || is_bpc;
  wire last_idx = idx_q == len_q - 6'd1;

  assign bcnt_cl = (bcnt_q > 8'd32) ? 6'd32 : bcnt_q[5:0];
  assign wlen = (is_bd && !rd) ? 6'd1 :
                ((is_word && !rd) || is_pc) ? 6'd2 :
                ((is_blk && !rd) || is_bpc || (is_i2c && !rd)) ? bcnt_cl : 6'd0;
  assign rlen = (is_bd && rd) ? 6'd1 :
                ((is_word && rd) || is_pc) ? 6'd2 :
                (is_i2c && rd) ? bcnt_cl : 6'd0;

  assign bus_req  = st != S_IDLE;
  assign bus_last = (st == S_RDATA && last_idx && !pec_en) || st == S_RPEC;

  always_comb begin
    case (st)
      S_START, S_RSTART:                                bus_op = 2'd0;
      S_ADDRW, S_ADDRR, S_CMD, S_WCNT, S_WDATA, S_WPEC: bus_op = 2'd1;
      S_RCNT, S_RDATA, S_RPEC:                          bus_op = 2'd2;
      default:                                          bus_op = 2'd3;
    endcase
    case (st)
      S_ADDRW: bus_tx = {addr_q[7:1], first_rd};
      S_ADDRR: bus_tx = {addr_q[7:1], 1'b1};
      S_CMD:   bus_tx = cmd_q;
      S_WCNT:  bus_tx = {2'b00, wlen};
      S_WDATA: bus_tx = data_q[idx_q[4:0]];
      S_WPEC:  bus_tx = crc_q;
      default: bus_tx = 8'h00;
    endcase
  end

  always_comb begin
    st_d  = st;
    idx_d = idx_q;
    len_d = len_q;
    err   = 1'b0;
    errc  = 5'h00;
    rn    = (st == S_RCNT) ? bus_rx[5:0] : rlen;
    if (bus_rsp) begin
      case (st)
        S_START:  st_d = S_ADDRW;
        S_RSTART: st_d = S_ADDRR;
        S_ADDRW, S_ADDRR: begin
          if (bus_nack) begin
            st_d = S_STOP; err = 1'b1; errc = 5'h10;
          end else if (st == S_ADDRR) begin
            if (cnt_in) st_d = S_RCNT;
            else if (rn != 6'd0) begin st_d = S_RDATA; idx_d = 6'd0; len_d = rn; end
            else st_d = pec_en ? S_RPEC : S_STOP;
          end else if (is_quick) st_d = S_STOP;
          else if (is_byte && rd) begin st_d = S_RDATA; idx_d = 6'd0; len_d = 6'd1; end
          else st_d = S_CMD;
        end
        S_CMD, S_WCNT, S_WDATA: begin
          if (bus_nack) begin
            st_d = S_STOP; err = 1'b1; errc = 5'h11;
          end else if (st == S_CMD && cnt_out) st_d = S_WCNT;
          else if (st != S_WDATA && wlen != 6'd0) begin st_d = S_WDATA; idx_d = 6'd0; len_d = wlen; end
          else if (st == S_WDATA && !last_idx) idx_d = idx_q + 6'd1;
          else st_d = rd_phase ? S_RSTART : (pec_en ? S_WPEC : S_STOP);
        end
        S_RCNT: begin
          if (bus_rx > 8'd32) begin st_d = S_STOP; err = 1'b1; errc = 5'h11; end
          else if (rn != 6'd0) begin st_d = S_RDATA; idx_d = 6'd0; len_d = rn; end
          else st_d = pec_en ? S_RPEC : S_STOP;
        end
        S_RDATA: begin
          if (last_idx) st_d = pec_en ? S_RPEC : S_STOP;
          else idx_d = idx_q + 6'd1;
        end
        S_WPEC: begin
          st_d = S_STOP;
          if (bus_nack) begin err = 1'b1; errc = 5'h11; end
        end
        S_RPEC: begin
          st_d = S_STOP;
          if (bus_rx != crc_q) begin err = 1'b1; errc = 5'h1F; end
        end
        S_STOP:  st_d = S_IDLE;
        default: st_d = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx_q <= '0; len_q <= '0; code_q <= '0; done_q <= 1'b0;
      prot_q <= '0; addr_q <= '0; cmd_q <= '0; bcnt_q <= '0; crc_q <= '0;
      alrm_a_q <= '0; alrm_d0_q <= '0; alrm_d1_q <= '0;
      for (int i = 0; i < BUF_N; i++) data_q[i] <= '0;
    end else begin
      st <= st_d; idx_q <= idx_d; len_q <= len_d;
      if (err) code_q <= errc;
      if (bus_rsp && st != S_IDLE) begin
        if (bus_op == 2'd1) crc_q <= crc8(crc_q, bus_tx);
        if (st == S_RCNT || st == S_RDATA) crc_q <= crc8(crc_q, bus_rx);
        if (st == S_RDATA) data_q[idx_q[4:0]] <= bus_rx;
        if (st == S_RCNT && bus_rx <= 8'd32) bcnt_q <= bus_rx;
        if (st == S_STOP) done_q <= 1'b1;
      end
      if (reg_we && st == S_IDLE) begin
        if (reg_addr >= DATA_LO && reg_addr <= DATA_HI) data_q[5'(reg_addr - DATA_LO)] <= reg_wdata;
        case (reg_addr)
          6'h00: begin
            prot_q <= reg_wdata; crc_q <= '0;
            if (supported(reg_wdata)) begin
              st <= S_START; done_q <= 1'b0; code_q <= 5'h00;
            end else begin
              done_q <= 1'b1; code_q <= 5'h19;
            end
          end
          6'h02: addr_q    <= reg_wdata;
          6'h03: cmd_q     <= reg_wdata;
          6'h24: bcnt_q    <= reg_wdata;
          6'h25: alrm_a_q  <= reg_wdata;
          6'h26: alrm_d0_q <= reg_wdata;
          6'h27: alrm_d1_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr >= DATA_LO && reg_addr <= DATA_HI) reg_rdata = data_q[5'(reg_addr - DATA_LO)];
    else case (reg_addr)
      6'h00: reg_rdata = prot_q;
      6'h01: reg_rdata = {done_q, 2'b00, code_q};
      6'h02: reg_rdata = addr_q;
      6'h03: reg_rdata = cmd_q;
      6'h24: reg_rdata = bcnt_q;
      6'h25: reg_rdata = alrm_a_q;
      6'h26: reg_rdata = alrm_d0_q;
      6'h27: reg_rdata = alrm_d1_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_busy_not_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |-> !done_q);
  assert_reject_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 6'h00 && st == S_IDLE && !supported(reg_wdata)) |=> (done_q && code_q == 5'h19 && st == S_IDLE));
  assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rsp) |=> (bus_req && $stable(bus_op) && $stable(bus_tx)));
  assert_index_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATA || st == S_RDATA) |-> (idx_q < len_q && len_q <= 6'd32));
  assert_addr_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_ADDRW || st == S_ADDRR) && bus_rsp && bus_nack) |=> (st == S_STOP && code_q == 5'h10));
  assert_count_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RCNT && bus_rsp && bus_rx > 8'd32) |=> (st == S_STOP && code_q == 5'h11 && $stable(bcnt_q)));
  assert_busy_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && reg_we) |=> ($stable(prot_q) && $stable(addr_q) && $stable(cmd_q)));
endmodule

// File: tb/smbus_seq_bench.sv
`timescale 1ns/1ps
module smbus_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0, reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, bus_tx, bus_rx = '0;
  logic bus_req, bus_last, bus_rsp = 1'b0, bus_nack = 1'b0;
  logic [1:0] bus_op;

  smbus_seq u_smbus_seq (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_op(bus_op),
    .bus_tx(bus_tx), .bus_last(bus_last), .bus_rsp(bus_rsp), .bus_nack(bus_nack), .bus_rx(bus_rx));

  int errors = 0, checks = 0;
  logic [10:0] lg [128];
  logic [10:0] ex [128];
  logic [7:0] rxq [80];
  logic [7:0] rdat [40];
  logic [7:0] wd [32];
  int lgn, exn, rxn, rxp, sendn, nack_at, rdn;
  logic [7:0] ecrc, addr_v, cmd_v, bcnt_v, rcnt_v;

  always @(negedge clk) begin
    if (bus_rsp) begin
      bus_rsp = 1'b0; bus_nack = 1'b0;
    end else if (bus_req) begin
      bus_rsp = 1'b1; bus_nack = 1'b0;
      if (bus_op == 2'd1) begin
        bus_nack = (sendn == nack_at); sendn++;
        if (lgn < 128) lg[lgn] = {1'b0, 2'd1, bus_tx};
      end else if (bus_op == 2'd2) begin
        bus_rx = rxq[rxp % 80]; rxp++;
        if (lgn < 128) lg[lgn] = {bus_last, 2'd2, bus_rx};
      end else if (lgn < 128) lg[lgn] = {1'b0, bus_op, 8'h00};
      lgn++;
    end
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] rxv(input int i);
    return 8'(8'h5A + i * 29);
  endfunction

  function automatic logic sup(input logic [7:0] p);
    return (p[6:1] inside {6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h25}) || p[6:0] == 7'h0C || p[6:0] == 7'h0D;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clear_run();
    lgn = 0; exn = 0; rxn = 0; rxp = 0; sendn = 0; nack_at = -1; ecrc = 8'h00; rdn = 0;
  endtask

  task automatic e_start(); ex[exn] = {1'b0, 2'd0, 8'h00}; exn++; endtask
  task automatic e_stop();  ex[exn] = {1'b0, 2'd3, 8'h00}; exn++; endtask
  task automatic e_send(input logic [7:0] b);
    ex[exn] = {1'b0, 2'd1, b}; exn++; ecrc = crc8(ecrc, b);
  endtask
  task automatic e_recv(input logic [7:0] b, input logic last, input logic upd);
    ex[exn] = {last, 2'd2, b}; exn++; rxq[rxn] = b; rxn++;
    if (upd) ecrc = crc8(ecrc, b);
  endtask
  task automatic add_rd(input int i, input logic last);
    e_recv(rxv(i), last, 1'b1); rdat[rdn] = rxv(i); rdn++;
  endtask

  task automatic setup();
    wr(6'h02, addr_v); wr(6'h03, cmd_v); wr(6'h24, bcnt_v);
    for (int i = 0; i < 32; i++) wr(6'(4 + i), wd[i]);
  endtask

  task automatic build(input logic [7:0] p);
    logic r, pe, blk, bpc, pc, bd, wo, i2c;
    int nw, wn, rn;
    r = p[0]; pe = p[7] && p[6:1] != 6'h01;
    bd = p[6:1] == 6'h03; wo = p[6:1] == 6'h04; blk = p[6:1] == 6'h05;
    i2c = p[6:1] == 6'h25; pc = p[6:0] == 7'h0C; bpc = p[6:0] == 7'h0D;
    nw = (bcnt_v > 32) ? 32 : int'(bcnt_v);
    e_start();
    if (p[6:1] == 6'h01) begin
      e_send({addr_v[7:1], r}); e_stop();
    end else if (p[6:1] == 6'h02 && r) begin
      e_send({addr_v[7:1], 1'b1}); add_rd(0, !pe);
      if (pe) e_recv(ecrc, 1'b1, 1'b0);
      e_stop();
    end else begin
      e_send({addr_v[7:1], 1'b0}); e_send(cmd_v);
      if ((blk && !r) || bpc) e_send(8'(nw));
      wn = (bd && !r) ? 1 : ((wo && !r) || pc) ? 2 : ((blk && !r) || bpc || (i2c && !r)) ? nw : 0;
      for (int i = 0; i < wn; i++) e_send(wd[i]);
      if ((r && (bd || wo || blk || i2c)) || pc || bpc) begin
        e_start(); e_send({addr_v[7:1], 1'b1});
        if ((blk && r) || bpc) e_recv(rcnt_v, 1'b0, 1'b1);
        rn = ((blk && r) || bpc) ? int'(rcnt_v) : bd ? 1 : (wo || pc) ? 2 : i2c ? nw : 0;
        for (int i = 0; i < rn; i++) add_rd(i, i == rn - 1 && !pe);
        if (pe) e_recv(ecrc, 1'b1, 1'b0);
      end else if (pe) e_send(ecrc);
      e_stop();
    end
  endtask

  task automatic waitdone(output logic [7:0] s);
    s = 8'h00;
    for (int i = 0; i < 3000 && !s[7]; i++) rd(6'h01, s);
  endtask

  task automatic cmp_log(input string tag);
    logic ok;
    int bad;
    ok = (lgn == exn); bad = -1;
    for (int i = 0; i < exn && i < 128; i++) if (lg[i] !== ex[i] && bad < 0) begin ok = 1'b0; bad = i; end
    chk(ok, tag, (bad >= 0) ? int'(lg[bad]) : lgn, (bad >= 0) ? int'(ex[bad]) : exn);
  endtask

  task automatic check_rd(input string tag);
    logic [7:0] v;
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < rdn; i++) begin rd(6'(4 + i), v); if (v !== rdat[i]) ok = 1'b0; end
    chk(ok, tag, rdn, rdn);
  endtask

  task automatic run_std(input logic [7:0] p, input string tag);
    logic [7:0] s;
    clear_run(); setup(); build(p);
    wr(6'h00, p); waitdone(s);
    chk(s == 8'h80, {tag, " status R2"}, s, 8'h80);
    cmp_log({tag, " steps R5 R6 R7 R11 R13"});
    if (rdn > 0) check_rd({tag, " read data R6"});
    if (p[0] && p[6:1] == 6'h05 || p[6:0] == 7'h0D) begin
      rd(6'h24, s); chk(s == rcnt_v, {tag, " count stored R6"}, s, rcnt_v);
    end
  endtask

  logic [7:0] codes [14] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
                             8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h4A, 8'h4B};

  initial begin
    #(5ns * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, s;
    logic ok;
    for (int i = 0; i < 32; i++) wd[i] = 8'(8'hC1 + i * 7);
    addr_v = 8'hA5; cmd_v = 8'h3E; bcnt_v = 8'd3; rcnt_v = 8'd3;
    clear_run();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    ok = 1'b1;
    for (int a = 0; a < 64; a++) begin rd(6'(a), v); if (v !== 8'h00) ok = 1'b0; end
    chk(ok && !bus_req, "reset values R1", int'(bus_req), 0);

    for (int a = 1; a < 64; a++) wr(6'(a), 8'(a * 37 + 5));
    ok = 1'b1;
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), v);
      if (v !== ((a >= 2 && a <= 6'h27) ? 8'(a * 37 + 5) : 8'h00)) ok = 1'b0;
    end
    chk(ok, "readback and unmapped R1", int'(ok), 1);

    clear_run(); ok = 1'b1;
    for (int p = 0; p < 256; p++) if (!sup(8'(p))) begin
      wr(6'h00, 8'(p)); rd(6'h01, s);
      if (s !== 8'h99) ok = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(ok, "unsupported codes R3", int'(ok), 1);
    chk(lgn == 0, "no bus steps for unsupported R3", lgn, 0);

    for (int pe = 0; pe < 2; pe++)
      for (int k = 0; k < 14; k++)
        run_std(codes[k] | (pe ? 8'h80 : 8'h00), $sformatf("proto %02h", codes[k] | (pe ? 8'h80 : 8'h00)));

    bcnt_v = 8'd40; run_std(8'h8A, "clamped block write R8");
    rd(6'h24, v); chk(v == 8'd40, "count kept on write R8", v, 40);
    bcnt_v = 8'd3;
    rcnt_v = 8'd32; run_std(8'h8B, "block read 32 R6");
    rcnt_v = 8'd0;  run_std(8'h0B, "block read 0 R13");
    rcnt_v = 8'd3;

    clear_run(); setup(); nack_at = 0;
    e_start(); e_send({addr_v[7:1], 1'b0}); e_stop();
    wr(6'h00, 8'h08); waitdone(s);
    chk(s == 8'h90, "address nack R9", s, 8'h90); cmp_log("address nack steps R9");

    clear_run(); setup(); nack_at = 2;
    e_start(); e_send({addr_v[7:1], 1'b0}); e_send(cmd_v); e_send(wd[0]); e_stop();
    wr(6'h00, 8'h08); waitdone(s);
    chk(s == 8'h91, "data nack R9", s, 8'h91); cmp_log("data nack steps R9");

    clear_run(); setup(); nack_at = 2;
    e_start(); e_send({addr_v[7:1], 1'b0}); e_send(cmd_v); e_start(); e_send({addr_v[7:1], 1'b1}); e_stop();
    wr(6'h00, 8'h07); waitdone(s);
    chk(s == 8'h90, "restart address nack R9", s, 8'h90); cmp_log("restart nack steps R9");

    bcnt_v = 8'd5;
    clear_run(); setup();
    e_start(); e_send({addr_v[7:1], 1'b0}); e_send(cmd_v); e_start(); e_send({addr_v[7:1], 1'b1});
    e_recv(8'd33, 1'b0, 1'b1); e_stop();
    wr(6'h00, 8'h8B); waitdone(s);
    chk(s == 8'h91, "count 33 R10", s, 8'h91); cmp_log("count 33 steps R10");
    rd(6'h24, v); chk(v == 8'd5, "count reg kept R10", v, 5);
    bcnt_v = 8'd3;

    clear_run(); setup(); build(8'h89);
    rxq[rxn - 1] = rxq[rxn - 1] ^ 8'h01;
    wr(6'h00, 8'h89); waitdone(s);
    chk(s == 8'h9F, "pec mismatch R11", s, 8'h9F);
    check_rd("pec mismatch data R6");

    clear_run(); setup(); build(8'h0A);
    wr(6'h00, 8'h0A);
    rd(6'h01, s); chk(s == 8'h00, "done clear while busy R2", s, 0);
    wr(6'h03, 8'h77); wr(6'h00, 8'h02);
    waitdone(s);
    chk(s == 8'h80, "busy status R12", s, 8'h80);
    cmp_log("busy writes ignored steps R12");
    rd(6'h03, v); chk(v == cmd_v, "command kept R12", v, cmd_v);
    rd(6'h00, v); chk(v == 8'h0A, "protocol kept R12", v, 8'h0A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule